// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. Once a start request is accepted, it holds the sampling front end in a tracking phase for a programmable number of conversion-clock steps. It then resolves the result one bit per step, most significant bit first. Each step places a trial code on `trial_code` for an external DAC and comparator. At the end of the step it reads the single comparator bit back on `cmp_in`.

Conversion-clock steps are derived from the system clock by a programmable divider, which restarts on every accepted start. The total conversion time is therefore fixed by the settings. A start may come from a software pulse or from a timer overflow, and a select input chooses between them.

After the last comparison, the code is written once into a 16-bit result word. The word holds either an unsigned value or a two's-complement differential value, placed right- or left-justified. A one-cycle `done` pulse marks the write.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `busy`, `done`, `tracking` are 0, and `result` and `trial_code` are all zeros.
- R2: With `src_sel`=0, only `sw_start` starts a conversion. With `src_sel`=1, only `tmr_ovf` does. A pulse on the source that is not selected leaves `busy` and `tracking` at 0.
- R3: A start request that arrives while `busy` is 1 is ignored. This includes a request in the final busy cycle, and afterwards `busy` stays 0.
- R4: `tracking` is high for exactly T×(`clk_div`+2) cycles immediately after acceptance, where T = `track_len`, or 1 when `track_len` is 0. `trial_code` is 0 while tracking.
- R5: The first trial code after tracking has only the most significant bit set (512 for 10 bits).
- R6: A trial bit is kept at 1 when `cmp_in` is 1 (the input exceeds the trial level) and cleared otherwise, and the next lower bit is then set for the following trial. The resulting code is the largest value strictly below the input, saturating at 0 and 2^N−1. An input at one third of the range gives 0101010101.
- R7: A conversion performs exactly N comparisons. `busy` is high for exactly (T+N)×(`clk_div`+2) cycles.
- R8: `result` changes only in the cycle `done` is 1. `done` is a one-cycle pulse that coincides with `busy` falling.
- R9: With `diff_mode`=0 and `left_just`=0, `result` is the unsigned code zero-extended in bits N−1..0.
- R10: With `diff_mode`=1, the value is code − 2^(N−1) in two's complement, covering −2^(N−1)..2^(N−1)−1. Mid-scale gives 0, and right-justified values are sign-extended.
- R11: With `left_just`=1, the N-bit value (unsigned or two's complement) occupies bits 15..16−N and the lower bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 1 | Start source: 0 software pulse, 1 timer overflow |
| sw_start | input | 1 | Software start pulse |
| tmr_ovf | input | 1 | Timer overflow start pulse |
| clk_div | input | 4 | Conversion step length is `clk_div`+2 system clocks |
| track_len | input | 4 | Tracking length in steps (0 treated as 1) |
| diff_mode | input | 1 | 1 selects two's-complement differential output |
| left_just | input | 1 | 1 selects left-justified result placement |
| cmp_in | input | 1 | Comparator decision, 1 when input exceeds trial level |
| trial_code | output | 10 | Trial code presented to the DAC |
| tracking | output | 1 | High during the tracking phase |
| busy | output | 1 | High from acceptance until the result is written |
| done | output | 1 | One-cycle pulse when the result is written |
| result | output | 16 | Formatted conversion result |

## Verification
The interesting collision is a new start request landing in the very cycle whose closing edge resolves the last bit and writes the result. The bench provokes it by knowing the exact busy length and pulsing the selected start source in that last busy cycle. It judges the outcome by checking that the result is correct, that `done` pulses once, and that `busy` stays low afterwards. A second request in the middle of a conversion, on random runs, must likewise leave the busy length unchanged.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        SAR_IDLE    = 2'd0,
        SAR_TRACK   = 2'd1,
        SAR_RESOLVE = 2'd2
    } sar_phase_e;

    typedef enum logic {
        SRC_SOFT  = 1'b0,
        SRC_TIMER = 1'b1
    } start_src_e;

endpackage

// File: rtl/sar_start_sel.sv
module sar_start_sel
    import sar_seq_pkg::*;
(
    input  logic src_sel,
    input  logic sw_start,
    input  logic tmr_ovf,
    output logic start_req
);

    always_comb begin
        unique case (start_src_e'(src_sel))
            SRC_SOFT:  start_req = sw_start;
            SRC_TIMER: start_req = tmr_ovf;
            default:   start_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    localparam int CNT_W = DIV_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_state_t;

    tick_state_t cur_q, nxt_d;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = {1'b0, div_val} + CNT_ONE;
    assign tick     = run && (cur_q.cnt == last_cnt);

    always_comb begin
        nxt_d = cur_q;
        if (restart) begin
            nxt_d.cnt = '0;
        end else if (run) begin
            if (cur_q.cnt == last_cnt) nxt_d.cnt = '0;
            else                       nxt_d.cnt = cur_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R7: the step counter never passes its terminal value while running
    a_r7_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cur_q.cnt <= last_cnt));

    // R7: a step lasts at least two system clocks
    a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int TRK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             tick,
    input  logic [TRK_W-1:0] track_len,
    input  logic             cmp_in,
    output logic             restart,
    output logic             busy,
    output logic             tracking,
    output logic [RES_W-1:0] trial_code,
    output logic             raw_valid,
    output logic [RES_W-1:0] raw_code
);

    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(RES_W - 1);
    localparam logic [IDX_W-1:0] IDX_ONE  = 1;
    localparam logic [TRK_W-1:0] TRK_ONE  = 1;
    localparam logic [TRK_W:0]   TRK_ONEW = 1;
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        sar_phase_e       phase;
        logic [TRK_W-1:0] trk_cnt;
        logic [IDX_W-1:0] bit_idx;
        logic [RES_W-1:0] trial;
    } eng_state_t;

    eng_state_t cur_q, nxt_d;
    logic [TRK_W-1:0] trk_eff;

    assign trk_eff    = (track_len == '0) ? TRK_ONE : track_len;
    assign busy       = (cur_q.phase != SAR_IDLE);
    assign tracking   = (cur_q.phase == SAR_TRACK);
    assign trial_code = cur_q.trial;

    always_comb begin
        nxt_d     = cur_q;
        restart   = 1'b0;
        raw_valid = 1'b0;
        raw_code  = cur_q.trial;
        unique case (cur_q.phase)
            SAR_IDLE: begin
                if (start_req) begin
                    nxt_d.phase   = SAR_TRACK;
                    nxt_d.trk_cnt = '0;
                    nxt_d.bit_idx = '0;
                    nxt_d.trial   = '0;
                    restart       = 1'b1;
                end
            end
            SAR_TRACK: begin
                if (tick) begin
                    if (({1'b0, cur_q.trk_cnt} + TRK_ONEW) >= {1'b0, trk_eff}) begin
                        nxt_d.phase   = SAR_RESOLVE;
                        nxt_d.bit_idx = TOP_IDX;
                        nxt_d.trial   = MSB_ONLY;
                    end else begin
                        nxt_d.trk_cnt = cur_q.trk_cnt + TRK_ONE;
                    end
                end
            end
            SAR_RESOLVE: begin
                if (tick) begin
                    nxt_d.trial[cur_q.bit_idx] = cmp_in;
                    if (cur_q.bit_idx == '0) begin
                        nxt_d.phase = SAR_IDLE;
                        raw_valid   = 1'b1;
                        raw_code    = nxt_d.trial;
                    end else begin
                        nxt_d.trial[cur_q.bit_idx - IDX_ONE] = 1'b1;
                        nxt_d.bit_idx = cur_q.bit_idx - IDX_ONE;
                    end
                end
            end
            default: nxt_d.phase = SAR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{phase: SAR_IDLE, default: '0};
        else        cur_q <= nxt_d;
    end

    // R5: entering the bit trials presents the most significant bit alone
    a_r5_first_trial_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == SAR_RESOLVE && $past(cur_q.phase) == SAR_TRACK)
            |-> (trial_code == MSB_ONLY));

    // R4: no trial level is driven while the input is being tracked
    a_r4_zero_while_tracking: assert property (@(posedge clk) disable iff (!rst_n)
        tracking |-> (trial_code == '0));

    // R6: each resolved step moves exactly one bit lower
    a_r6_bit_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == SAR_RESOLVE && tick && cur_q.bit_idx != '0)
            |=> (cur_q.bit_idx == $past(cur_q.bit_idx) - IDX_ONE));

    // R3: a running conversion ends only through its last comparison
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !raw_valid) |=> busy);

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
    parameter int RES_W = 10,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] raw_code,
    input  logic             diff_mode,
    input  logic             left_just,
    output logic [OUT_W-1:0] result,
    output logic             done
);

    localparam int PAD_W = OUT_W - RES_W;

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             done;
    } fmt_state_t;

    fmt_state_t cur_q, nxt_d;
    logic [RES_W-1:0] val;
    logic [OUT_W-1:0] placed;

    always_comb begin
        val = raw_code;
        if (diff_mode) val[RES_W-1] = ~raw_code[RES_W-1];
    end

    always_comb begin
        if (left_just)      placed = {val, {PAD_W{1'b0}}};
        else if (diff_mode) placed = {{PAD_W{val[RES_W-1]}}, val};
        else                placed = {{PAD_W{1'b0}}, val};
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = load;
        if (load) nxt_d.word = placed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign result = cur_q.word;
    assign done   = cur_q.done;

    // R11: a left-placed word has nothing below the value field
    a_r11_left_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (load && left_just) |=> (result[PAD_W-1:0] == '0));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int RES_W = 10,
    parameter int OUT_W = 16,
    parameter int DIV_W = 4,
    parameter int TRK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic             sw_start,
    input  logic             tmr_ovf,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [TRK_W-1:0] track_len,
    input  logic             diff_mode,
    input  logic             left_just,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial_code,
    output logic             tracking,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] result
);

    logic start_req;
    logic restart;
    logic tick;
    logic raw_valid;
    logic [RES_W-1:0] raw_code;

    sar_start_sel u_start (
        .src_sel   (src_sel),
        .sw_start  (sw_start),
        .tmr_ovf   (tmr_ovf),
        .start_req (start_req)
    );

    sar_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (busy),
        .div_val (clk_div),
        .tick    (tick)
    );

    sar_bit_engine #(.RES_W(RES_W), .TRK_W(TRK_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .tick       (tick),
        .track_len  (track_len),
        .cmp_in     (cmp_in),
        .restart    (restart),
        .busy       (busy),
        .tracking   (tracking),
        .trial_code (trial_code),
        .raw_valid  (raw_valid),
        .raw_code   (raw_code)
    );

    sar_result_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (raw_valid),
        .raw_code  (raw_code),
        .diff_mode (diff_mode),
        .left_just (left_just),
        .result    (result),
        .done      (done)
    );

    // R8: the write pulse marks the end of busy
    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: the write pulse lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the result word changes only with the write pulse
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R4: tracking is part of the busy window
    a_r4_track_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tracking |-> busy);

endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;

    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_sel = 1'b0;
    logic        sw_start = 1'b0;
    logic        tmr_ovf = 1'b0;
    logic [3:0]  clk_div = 4'd0;
    logic [3:0]  track_len = 4'd3;
    logic        diff_mode = 1'b0;
    logic        left_just = 1'b0;
    logic        cmp_in;
    logic [N-1:0] trial_code;
    logic        tracking, busy, done;
    logic [15:0] result;

    int vin_fx = 0;   // input in quarter-LSB units
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    // ideal comparator: 1 when the input exceeds the trial level
    assign cmp_in = (vin_fx > int'(trial_code) * 4);

    sar_conv_seq i_sar_conv_seq (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sw_start(sw_start),
        .tmr_ovf(tmr_ovf), .clk_div(clk_div), .track_len(track_len),
        .diff_mode(diff_mode), .left_just(left_just), .cmp_in(cmp_in),
        .trial_code(trial_code), .tracking(tracking), .busy(busy),
        .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_raw(input int vin);
        int c;
        if (vin <= 0) return 0;
        c = (vin + 3) / 4 - 1;
        if (c > (1 << N) - 1) c = (1 << N) - 1;
        return c;
    endfunction

    function automatic logic [15:0] exp_word(input int vin, input bit diff, input bit lj);
        logic [N-1:0] v;
        v = N'(exp_raw(vin));
        if (diff) v[N-1] = ~v[N-1];
        if (lj)        return {v, 6'b0};
        else if (diff) return {{6{v[N-1]}}, v};
        else           return {6'b0, v};
    endfunction

    task automatic pulse_src(input bit sel);
        if (sel) tmr_ovf = 1'b1;
        else     sw_start = 1'b1;
    endtask

    task automatic run_conv(input int vin, input bit sel, input int div, input int trk,
                            input bit diff, input bit lj, input bit late_req, input string tag);
        int teff, len, tlen, busy_n, trk_n, guard, first_trial;
        bit got_first, hold_ok, trial_zero;
        logic [15:0] prev;
        vin_fx = vin; src_sel = sel; clk_div = 4'(div); track_len = 4'(trk);
        diff_mode = diff; left_just = lj;
        teff = (trk == 0) ? 1 : trk;
        len  = (teff + N) * (div + 2);
        tlen = teff * (div + 2);
        pulse_src(sel);
        @(negedge clk);
        busy_n = 0; trk_n = 0; guard = 0; first_trial = -1;
        got_first = 0; hold_ok = 1; trial_zero = 1;
        prev = result;
        while (guard < 2000) begin
            sw_start = 1'b0; tmr_ovf = 1'b0;
            if (done) break;
            if (busy) busy_n++;
            if (tracking) begin
                trk_n++;
                if (trial_code != '0) trial_zero = 0;
            end
            if (busy && !tracking && !got_first) begin
                got_first = 1; first_trial = int'(trial_code);
            end
            if (result != prev) hold_ok = 0;
            if (busy_n == 2 || (late_req && busy_n == len)) pulse_src(sel);
            guard++;
            @(negedge clk);
        end
        chk(done == 1'b1, {"R8 done seen ", tag}, done, 1);
        chk(busy == 1'b0, {"R8 busy falls with done ", tag}, busy, 0);
        chk(result == exp_word(vin, diff, lj),
            diff ? {"R10 R6 value ", tag} : (lj ? {"R11 R6 value ", tag} : {"R9 R6 value ", tag}),
            result, exp_word(vin, diff, lj));
        chk(busy_n == len, {"R7 busy length ", tag}, busy_n, len);
        chk(trk_n == tlen && trial_zero, {"R4 tracking length ", tag}, trk_n, tlen);
        chk(first_trial == (1 << (N - 1)), {"R5 first trial ", tag}, first_trial, 1 << (N - 1));
        chk(hold_ok, {"R8 result held while busy ", tag}, hold_ok, 1);
        @(negedge clk);
        chk(done == 1'b0, {"R8 done single cycle ", tag}, done, 0);
        chk(busy == 1'b0, {"R3 late request ignored ", tag}, busy, 0);
        @(negedge clk);
        chk(busy == 1'b0 && tracking == 1'b0, {"R3 still idle ", tag}, busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd715);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !tracking, "R1 flags", {busy, done, tracking}, 0);
        chk(result == '0 && trial_code == '0, "R1 result and trial", result, 0);

        // R2 unselected source ignored
        src_sel = 1'b1; sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !tracking, "R2 soft ignored with timer select", busy, 0);
        src_sel = 1'b0; tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !tracking, "R2 timer ignored with soft select", busy, 0);

        // directed corners
        run_conv(1365, 0, 0, 3, 0, 0, 1, "R6 third of range");
        run_conv(1365, 1, 2, 5, 0, 1, 0, "R11 left third");
        run_conv(0,    0, 1, 0, 0, 0, 1, "zero input track0");
        run_conv(5000, 1, 0, 1, 0, 0, 0, "R6 saturate high");
        run_conv(2049, 0, 0, 2, 1, 0, 1, "R10 mid scale");
        run_conv(0,    1, 3, 2, 1, 0, 0, "R10 most negative");
        run_conv(5000, 0, 1, 4, 1, 0, 0, "R10 most positive");
        run_conv(700,  1, 0, 3, 1, 1, 1, "R11 left differential");
        run_conv(4,    0, 0, 3, 0, 0, 0, "R6 exact one lsb");
        run_conv(5,    0, 0, 3, 0, 0, 0, "R6 just above one lsb");

        // constrained random
        for (int i = 0; i < 40; i++) begin
            run_conv(int'($urandom_range(4200, 0)), 1'($urandom_range(1, 0)),
                     int'($urandom_range(3, 0)), int'($urandom_range(7, 0)),
                     1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                     1'($urandom_range(1, 0)), "random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule